// File: doc/BRIEF.md
# Scan-Testable Universal 4-Bit Register

This block is a 4-bit synchronous register that steps through one of eight operations on every clock edge. The operations are hold, parallel load, increment, decrement, right shift, left shift, a pseudo-random feedback step and a data-fed CRC-4 step. A 3-bit mode select picks the operation, and the register value is always visible on the parallel output.

Each storage bit is a muxed-D scan cell. When scan enable is high, the four cells form one serial chain from the scan input to the scan output. A tester can then push in any state and read out any state without going through the functional logic. This makes the block suitable for practising scan-based test of a small datapath.

Top module: `uniscan_reg`

## Requirements
- R1: Reset is synchronous and active-low. At a rising edge where rst_n is 0, dout becomes 0000, whatever scan_en and mode_sel are.
- R2: With scan_en low and mode_sel = 000, dout keeps its value.
- R3: With scan_en low and mode_sel = 001, dout takes din.
- R4: With scan_en low and mode_sel = 010, dout increments by one modulo 16, so 1111 becomes 0000.
- R5: With scan_en low and mode_sel = 011, dout decrements by one modulo 16, so 0000 becomes 1111.
- R6: With scan_en low and mode_sel = 100, dout shifts right by one and bit 3 is filled from din[3].
- R7: With scan_en low and mode_sel = 101, dout shifts left by one and bit 0 is filled from din[0].
- R8: With scan_en low and mode_sel = 110, dout shifts left and the new bit 0 is old bit 3 XOR old bit 2. An all-zero value therefore stays all-zero.
- R9: With scan_en low and mode_sel = 111, the new value is {q[2], q[1], q[3]^din[0]^q[0], q[3]^din[0]}, where q is the old value.
- R10: With scan_en high, mode_sel and din are ignored. scan_in enters bit 0, and bits 0, 1 and 2 move into bits 1, 2 and 3.
- R11: scan_out always equals bit 3 of dout.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous active-low clear |
| mode_sel | input | 3 | Operation select (000 to 111) |
| din | input | 4 | Parallel data for load, shift fill and CRC |
| dout | output | 4 | Register contents |
| scan_in | input | 1 | Serial test data into bit 0 |
| scan_en | input | 1 | High selects the serial scan path |
| scan_out | output | 1 | Serial test data from bit 3 |

## Verification
The assertions assume that rst_n, scan_en, mode_sel, din and scan_in are never unknown at a rising edge. They also assume these inputs change only away from that edge, so that the sampled old value and new value line up with a single step. The bench drives every input only on falling edges and always with defined values. It takes every starting state through every mode with every din value, and it runs scan loads while mode_sel holds a non-hold value, to confirm that the mode select has no effect in scan mode.

// File: rtl/uniscan_pkg.sv
// Package: shared width and operation encoding for the scan-testable register.
// Assumes: the register is 4 bits wide; the CRC step is defined for that width only.
package uniscan_pkg;
    localparam int REG_W  = 4;
    localparam int MODE_W = 3;

    typedef enum logic [MODE_W-1:0] {
        OP_HOLD = 3'b000,
        OP_LOAD = 3'b001,
        OP_INC  = 3'b010,
        OP_DEC  = 3'b011,
        OP_SHR  = 3'b100,
        OP_SHL  = 3'b101,
        OP_LFSR = 3'b110,
        OP_CRC  = 3'b111
    } op_e;
endpackage

// File: rtl/uniscan_next.sv
// Module: uniscan_next
// Computes the functional next state from the current value, din and the operation.
// Assumes: purely combinational; scan and reset are handled in the cells.
module uniscan_next
    import uniscan_pkg::*;
(
    input  logic [REG_W-1:0] cur,
    input  logic [REG_W-1:0] din,
    input  op_e              op,
    output logic [REG_W-1:0] nxt
);
    localparam logic [REG_W-1:0] ONE = REG_W'(1);

    // Select the next value for the chosen operation.
    always_comb begin
        unique case (op)
            OP_HOLD: nxt = cur;
            OP_LOAD: nxt = din;
            OP_INC:  nxt = cur + ONE;
            OP_DEC:  nxt = cur - ONE;
            OP_SHR:  nxt = {din[REG_W-1], cur[REG_W-1:1]};
            OP_SHL:  nxt = {cur[REG_W-2:0], din[0]};
            OP_LFSR: nxt = {cur[REG_W-2:0], cur[REG_W-1] ^ cur[REG_W-2]};
            OP_CRC:  nxt = {cur[2], cur[1],
                            cur[3] ^ din[0] ^ cur[0],
                            cur[3] ^ din[0]};
            default: nxt = cur;
        endcase
    end
endmodule

// File: rtl/uniscan_cell.sv
// Module: uniscan_cell
// One muxed-D scan flip-flop: serial input when scan is enabled, functional input otherwise.
// Assumes: synchronous active-low reset that overrides the scan path.
module uniscan_cell (
    input  logic clk,
    input  logic rst_n,
    input  logic scan_en,
    input  logic d_func,
    input  logic d_scan,
    output logic q
);
    // Store reset, scan or functional data on the rising edge.
    always_ff @(posedge clk) begin
        if (!rst_n)
            q <= 1'b0;
        else if (scan_en)
            q <= d_scan;
        else
            q <= d_func;
    end
endmodule

// File: rtl/uniscan_reg.sv
// Module: uniscan_reg
// Top level: eight-operation 4-bit register built from a chain of scan cells.
// Assumes: single clock domain, inputs stable around the rising edge.
module uniscan_reg
    import uniscan_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [MODE_W-1:0] mode_sel,
    input  logic [REG_W-1:0]  din,
    output logic [REG_W-1:0]  dout,
    input  logic              scan_in,
    input  logic              scan_en,
    output logic              scan_out
);
    logic [REG_W-1:0] q;
    logic [REG_W-1:0] func_d;
    logic [REG_W-1:0] scan_d;
    op_e              op;

    assign op = op_e'(mode_sel);

    uniscan_next u_next (
        .cur (q),
        .din (din),
        .op  (op),
        .nxt (func_d)
    );

    // The chain runs from scan_in into bit 0 and up toward bit REG_W-1.
    generate
        for (genvar i = 0; i < REG_W; i++) begin : g_chain
            if (i == 0) begin : g_head
                assign scan_d[i] = scan_in;
            end else begin : g_link
                assign scan_d[i] = q[i-1];
            end
            uniscan_cell u_cell (
                .clk     (clk),
                .rst_n   (rst_n),
                .scan_en (scan_en),
                .d_func  (func_d[i]),
                .d_scan  (scan_d[i]),
                .q       (q[i])
            );
        end
    endgenerate

    assign dout     = q;
    assign scan_out = q[REG_W-1];

    // R1: a low reset sample clears the register regardless of the scan path.
    a_r1_reset_clears: assert property (@(posedge clk)
        !rst_n |=> dout == '0);

    // R2: hold keeps the value.
    a_r2_hold_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (!scan_en && mode_sel == 3'b000) |=> $stable(dout));

    // R4: increment step, wrapping.
    a_r4_count_up: assert property (@(posedge clk) disable iff (!rst_n)
        (!scan_en && mode_sel == 3'b010) |=> dout == $past(dout) + 4'd1);

    // R8: the feedback step never leaves the all-zero state.
    a_r8_lfsr_lockup: assert property (@(posedge clk) disable iff (!rst_n)
        (!scan_en && mode_sel == 3'b110 && dout == '0) |=> dout == '0);

    // R10: scan shift moves every bit up by one and takes scan_in at bit 0.
    a_r10_scan_shift: assert property (@(posedge clk) disable iff (!rst_n)
        scan_en |=> dout == {$past(dout[REG_W-2:0]), $past(scan_in)});
endmodule

// File: tb/uniscan_reg_tb.sv
`timescale 1ns/1ps
module uniscan_reg_tb;
    logic       clk = 1'b0;
    logic       rst_n;
    logic [2:0] mode_sel;
    logic [3:0] din;
    logic [3:0] dout;
    logic       scan_in;
    logic       scan_en;
    logic       scan_out;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    uniscan_reg u_dut (
        .clk      (clk),
        .rst_n    (rst_n),
        .mode_sel (mode_sel),
        .din      (din),
        .dout     (dout),
        .scan_in  (scan_in),
        .scan_en  (scan_en),
        .scan_out (scan_out)
    );

    always #10 clk = ~clk;

    // Expected next value computed from the requirement text.
    function automatic logic [3:0] model(input logic [2:0] m, input logic [3:0] q,
                                        input logic [3:0] d);
        case (m)
            3'd0: return q;
            3'd1: return d;
            3'd2: return 4'((int'(q) + 1) % 16);
            3'd3: return 4'((int'(q) + 15) % 16);
            3'd4: return {d[3], q[3], q[2], q[1]};
            3'd5: return {q[2], q[1], q[0], d[0]};
            3'd6: return {q[2], q[1], q[0], q[3] ^ q[2]};
            default: return {q[2], q[1], q[3] ^ d[0] ^ q[0], q[3] ^ d[0]};
        endcase
    endfunction

    function automatic string tag_of(input logic [2:0] m);
        case (m)
            3'd0: return "R2";
            3'd1: return "R3";
            3'd2: return "R4";
            3'd3: return "R5";
            3'd4: return "R6";
            3'd5: return "R7";
            3'd6: return "R8";
            default: return "R9";
        endcase
    endfunction

    task automatic check(input string req, input logic [3:0] got, input logic [3:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got %b expected %b", req, got, exp);
        end
    endtask

    // Drive inputs on a falling edge; results are read at the following falling edge.
    task automatic step(input logic r, input logic se, input logic si,
                        input logic [2:0] m, input logic [3:0] d);
        rst_n = r; scan_en = se; scan_in = si; mode_sel = m; din = d;
        @(negedge clk);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: got timeout expected completion");
        finish_run();
    end

    initial begin
        rst_n = 1'b0; scan_en = 1'b0; scan_in = 1'b0; mode_sel = 3'd0; din = 4'd0;
        @(negedge clk);
        step(1'b0, 1'b0, 1'b0, 3'd0, 4'd0);
        check("R1", dout, 4'd0);

        // Exhaustive functional sweep: every mode, start value and din (R2..R9).
        for (int m = 0; m < 8; m++) begin
            for (int s = 0; s < 16; s++) begin
                for (int d = 0; d < 16; d++) begin
                    step(1'b1, 1'b0, 1'b0, 3'd1, 4'(s));
                    step(1'b1, 1'b0, 1'b0, 3'(m), 4'(d));
                    check(tag_of(3'(m)), dout, model(3'(m), 4'(s), 4'(d)));
                    check("R11", {3'b000, scan_out}, {3'b000, dout[3]});
                end
            end
        end

        // R4/R5 explicit wrap corners.
        step(1'b1, 1'b0, 1'b0, 3'd1, 4'hF);
        step(1'b1, 1'b0, 1'b0, 3'd2, 4'h0);
        check("R4", dout, 4'h0);
        step(1'b1, 1'b0, 1'b0, 3'd3, 4'h0);
        check("R5", dout, 4'hF);

        // R8 lock-up: zero stays zero over many feedback steps.
        step(1'b1, 1'b0, 1'b0, 3'd1, 4'h0);
        for (int k = 0; k < 20; k++) begin
            step(1'b1, 1'b0, 1'b0, 3'd6, 4'hF);
            check("R8", dout, 4'h0);
        end

        // R10/R11: scan every value in with a busy mode select, then scan it out.
        for (int v = 0; v < 16; v++) begin
            step(1'b1, 1'b0, 1'b0, 3'd1, 4'(15 - v));
            for (int b = 3; b >= 0; b--) begin
                step(1'b1, 1'b1, v[b], 3'(v % 7 + 1), 4'(~v));
            end
            check("R10", dout, 4'(v));
            for (int b = 3; b >= 0; b--) begin
                check("R11", {3'b000, scan_out}, {3'b000, v[b]});
                step(1'b1, 1'b1, 1'b1, 3'd2, 4'hA);
            end
            check("R10", dout, 4'hF);
        end

        // R1 priority: reset wins over scan enable.
        step(1'b1, 1'b0, 1'b0, 3'd1, 4'hA);
        step(1'b0, 1'b1, 1'b1, 3'd2, 4'hF);
        check("R1", dout, 4'h0);
        check("R11", {3'b000, scan_out}, 4'h0);

        finish_run();
    end
endmodule